// File: doc/BRIEF.md
# UART Host Register Interface

This block is the processor-facing side of one serial channel. It decodes a 3-bit address, read and write strobes and a pair of active-low chip selects. It keeps the channel's control state: line control, FIFO control, modem control, interrupt enable, a 16-bit baud divisor and a scratch byte. The transmitter, receiver and baud generator read these values from dedicated output ports. Receive data, line status, modem status and interrupt identification arrive as inputs and are returned on reads. The serial shifters, the FIFOs and interrupt prioritisation are in the neighbouring blocks.

Bit 7 of the line control register is a bank bit. It switches addresses 0 and 1 between the data and interrupt-enable registers and the two divisor bytes. Address 2 reaches a different register on reads than on writes. A write to the transmit holding register sends a one-cycle load strobe to the transmitter. A read of the receive buffer sends a one-cycle consume strobe to the receiver. Data words of fewer than eight bits are trimmed toward bit 0, according to the word-length field.

Top module: `uart_hostregs`

## Requirements
- R1: A bus cycle acts only while cs0_n or cs1_n is low. With both high, writes change nothing and rdata is 0.
- R2: After reset, every control output (line, FIFO, modem, interrupt enable, divisor, transmit data) is 0, and tx_load_o and rx_take_o are 0.
- R3: With bank bit line_ctrl_o[7] clear, a write to address 0 loads the transmit holding value and raises tx_load_o for exactly the following cycle. A write to address 1 sets int_enable_o.
- R4: With the bank bit set, address 0 writes and reads divisor_o[7:0], and address 1 writes and reads divisor_o[15:8]. Neither raises tx_load_o, and neither touches the transmit data or the interrupt enable. The divisor changes only on such writes.
- R5: Whatever the bank bit, a read of address 2 returns int_ident_i, and a write to address 2 sets fifo_ctrl_o.
- R6: Whatever the bank bit, addresses 3, 4, 5, 6 and 7 select line control (read/write), modem control (read/write), line_status_i (read), modem_status_i (read) and a scratch byte (read/write).
- R7: Writes to addresses 5 and 6 are ignored. No stored register changes.
- R8: Word length is line_ctrl_o[1:0]: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. tx_data_o and receive-buffer reads keep only that many low bits, and the upper bits are 0.
- R9: A read of address 0 with the bank bit clear raises rx_take_o for exactly the following cycle. Reads with the bank bit set do not raise it.
- R10: rdata is combinational from the current address while a selected read is active, and is 0 while rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs0_n | input | 1 | Chip select, active low |
| cs1_n | input | 1 | Chip select, active low |
| addr | input | 3 | Register address |
| rd | input | 1 | Read strobe, one access per cycle it is high |
| wr | input | 1 | Write strobe, one access per cycle it is high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rx_data_i | input | 8 | Received word from the receiver |
| line_status_i | input | 8 | Line status from the channel |
| modem_status_i | input | 8 | Modem status from the channel |
| int_ident_i | input | 8 | Interrupt identification from the interrupt logic |
| tx_data_o | output | 8 | Transmit holding value, trimmed to word length |
| tx_load_o | output | 1 | One-cycle strobe after a transmit holding write |
| rx_take_o | output | 1 | One-cycle strobe after a receive buffer read |
| line_ctrl_o | output | 8 | Line control register (bit 7 is the bank bit) |
| fifo_ctrl_o | output | 8 | FIFO control register |
| modem_ctrl_o | output | 8 | Modem control register |
| int_enable_o | output | 8 | Interrupt enable register |
| divisor_o | output | 16 | Baud divisor |

## Verification
The assertions assume that the host never raises rd and wr in the same cycle. They also assume that rd and wr are sampled as one access per clock, and that the chip selects, address and strobes are stable around each rising edge. The bench drives every access on the falling edge and holds it for one full cycle, with only one strobe active. It changes the bank bit only through ordinary line-control writes, so every strobe and divisor change seen by the assertions follows from a single decoded access.

// File: rtl/uart_hostregs_pkg.sv
package uart_hostregs_pkg;

   // decoded register target of one bus access
   typedef enum logic [3:0] {
      TGT_NONE      = 4'd0,
      TGT_DATA      = 4'd1,   // receive buffer (read) / transmit holding (write)
      TGT_IEN       = 4'd2,
      TGT_DIV_LO    = 4'd3,
      TGT_DIV_HI    = 4'd4,
      TGT_IDENT_FCR = 4'd5,   // identification (read) / FIFO control (write)
      TGT_LINE      = 4'd6,
      TGT_MODEM     = 4'd7,
      TGT_LSTAT     = 4'd8,
      TGT_MSTAT     = 4'd9,
      TGT_SCRATCH   = 4'd10
   } target_t;

   localparam int unsigned BANK_BIT   = 7;
   localparam int unsigned MIN_WORD   = 5;
   localparam int unsigned WLEN_LSB   = 0;
   localparam int unsigned WLEN_W     = 2;

endpackage

// File: rtl/uart_hr_decode.sv
module uart_hr_decode
   import uart_hostregs_pkg::*;
#(
   parameter int unsigned ADDR_W = 3
) (
   input  logic              cs0_n,
   input  logic              cs1_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              bank,
   output logic              sel,
   output target_t           target
);

   localparam int unsigned N_ADDR = 1 << ADDR_W;

   if (ADDR_W != 3) begin : g_bad_addr
      $error("uart_hr_decode: ADDR_W must be 3");
   end

   assign sel = !(cs0_n && cs1_n);

   always_comb begin
      target = TGT_NONE;
      if (sel) begin
         unique case (addr)
            3'd0:    target = bank ? TGT_DIV_LO : TGT_DATA;
            3'd1:    target = bank ? TGT_DIV_HI : TGT_IEN;
            3'd2:    target = TGT_IDENT_FCR;
            3'd3:    target = TGT_LINE;
            3'd4:    target = TGT_MODEM;
            3'd5:    target = TGT_LSTAT;
            3'd6:    target = TGT_MSTAT;
            default: target = TGT_SCRATCH;
         endcase
      end
   end

   // N_ADDR kept for derived checks of the address space
   if (N_ADDR != 8) begin : g_bad_space
      $error("uart_hr_decode: address space must hold 8 registers");
   end

endmodule

// File: rtl/uart_hr_trim.sv
module uart_hr_trim
   import uart_hostregs_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter bit          TRIM_WORDS = 1'b1
) (
   input  logic [WLEN_W-1:0] wlen,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   if (DATA_W < 8) begin : g_bad_width
      $error("uart_hr_trim: DATA_W must be at least 8");
   end

   if (TRIM_WORDS) begin : g_trim
      logic [DATA_W-1:0] mask;
      always_comb begin
         for (int i = 0; i < DATA_W; i++) begin
            mask[i] = (i < (MIN_WORD + int'(wlen)));
         end
      end
      assign dout = din & mask;
   end else begin : g_pass
      logic [WLEN_W-1:0] wlen_unused;
      assign wlen_unused = wlen;
      assign dout = din;
   end

endmodule

// File: rtl/uart_hr_regs.sv
module uart_hr_regs
   import uart_hostregs_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DIV_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  target_t           target,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] line_q,
   output logic [DATA_W-1:0] fifo_q,
   output logic [DATA_W-1:0] modem_q,
   output logic [DATA_W-1:0] ien_q,
   output logic [DATA_W-1:0] scratch_q,
   output logic [DATA_W-1:0] hold_q,
   output logic [DIV_W-1:0]  div_q,
   output logic              load_q,
   output logic              take_q
);

   localparam int unsigned DIV_BYTES = DIV_W / DATA_W;

   if (DIV_BYTES != 2 || (DIV_W % DATA_W) != 0) begin : g_bad_div
      $error("uart_hr_regs: divisor must be exactly two data bytes");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q    <= '0;
         fifo_q    <= '0;
         modem_q   <= '0;
         ien_q     <= '0;
         scratch_q <= '0;
         hold_q    <= '0;
      end else if (wr_en) begin
         unique case (target)
            TGT_DATA:      hold_q    <= wdata;
            TGT_IEN:       ien_q     <= wdata;
            TGT_IDENT_FCR: fifo_q    <= wdata;
            TGT_LINE:      line_q    <= wdata;
            TGT_MODEM:     modem_q   <= wdata;
            TGT_SCRATCH:   scratch_q <= wdata;
            default:       ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= 1'b0;
         take_q <= 1'b0;
      end else begin
         load_q <= wr_en && (target == TGT_DATA);
         take_q <= rd_en && (target == TGT_DATA);
      end
   end

   for (genvar b = 0; b < DIV_BYTES; b++) begin : g_div
      localparam target_t MY_TGT = (b == 0) ? TGT_DIV_LO : TGT_DIV_HI;
      logic [DATA_W-1:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            byte_q <= '0;
         else if (wr_en && target == MY_TGT)    byte_q <= wdata;
      end
      assign div_q[b*DATA_W +: DATA_W] = byte_q;
   end

   AST_FCR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fifo_q) |-> $past(wr_en && target == TGT_IDENT_FCR)); // R5

   AST_SCRATCH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(scratch_q) |-> $past(wr_en && target == TGT_SCRATCH)); // R6

endmodule

// File: rtl/uart_hr_rdmux.sv
module uart_hr_rdmux
   import uart_hostregs_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DIV_W  = 16
) (
   input  logic              rd_en,
   input  target_t           target,
   input  logic [DATA_W-1:0] rx_trim,
   input  logic [DATA_W-1:0] ien_q,
   input  logic [DIV_W-1:0]  div_q,
   input  logic [DATA_W-1:0] ident,
   input  logic [DATA_W-1:0] line_q,
   input  logic [DATA_W-1:0] modem_q,
   input  logic [DATA_W-1:0] lstat,
   input  logic [DATA_W-1:0] mstat,
   input  logic [DATA_W-1:0] scratch_q,
   output logic [DATA_W-1:0] rdata
);

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         unique case (target)
            TGT_DATA:      rdata = rx_trim;
            TGT_IEN:       rdata = ien_q;
            TGT_DIV_LO:    rdata = div_q[DATA_W-1:0];
            TGT_DIV_HI:    rdata = div_q[DIV_W-1:DATA_W];
            TGT_IDENT_FCR: rdata = ident;
            TGT_LINE:      rdata = line_q;
            TGT_MODEM:     rdata = modem_q;
            TGT_LSTAT:     rdata = lstat;
            TGT_MSTAT:     rdata = mstat;
            TGT_SCRATCH:   rdata = scratch_q;
            default:       rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/uart_hostregs.sv
module uart_hostregs
   import uart_hostregs_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned DIV_W      = 2 * DATA_W,
   parameter bit          TRIM_WORDS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs0_n,
   input  logic              cs1_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] rx_data_i,
   input  logic [DATA_W-1:0] line_status_i,
   input  logic [DATA_W-1:0] modem_status_i,
   input  logic [DATA_W-1:0] int_ident_i,
   output logic [DATA_W-1:0] tx_data_o,
   output logic              tx_load_o,
   output logic              rx_take_o,
   output logic [DATA_W-1:0] line_ctrl_o,
   output logic [DATA_W-1:0] fifo_ctrl_o,
   output logic [DATA_W-1:0] modem_ctrl_o,
   output logic [DATA_W-1:0] int_enable_o,
   output logic [DIV_W-1:0]  divisor_o
);

   logic              sel;
   target_t           target;
   logic [DATA_W-1:0] line_q, fifo_q, modem_q, ien_q, scratch_q, hold_q;
   logic [DIV_W-1:0]  div_q;
   logic              load_q, take_q;
   logic [DATA_W-1:0] rx_trim, tx_trim;
   logic              bank;
   logic [WLEN_W-1:0] wlen;

   assign bank = line_q[BANK_BIT];
   assign wlen = line_q[WLEN_LSB +: WLEN_W];

   uart_hr_decode #(.ADDR_W(ADDR_W)) u_decode (
      .cs0_n (cs0_n), .cs1_n (cs1_n), .addr (addr), .bank (bank),
      .sel (sel), .target (target)
   );

   uart_hr_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
      .clk (clk), .rst_n (rst_n),
      .wr_en (wr && sel), .rd_en (rd && sel), .target (target), .wdata (wdata),
      .line_q (line_q), .fifo_q (fifo_q), .modem_q (modem_q), .ien_q (ien_q),
      .scratch_q (scratch_q), .hold_q (hold_q), .div_q (div_q),
      .load_q (load_q), .take_q (take_q)
   );

   uart_hr_trim #(.DATA_W(DATA_W), .TRIM_WORDS(TRIM_WORDS)) u_trim_rx (
      .wlen (wlen), .din (rx_data_i), .dout (rx_trim)
   );

   uart_hr_trim #(.DATA_W(DATA_W), .TRIM_WORDS(TRIM_WORDS)) u_trim_tx (
      .wlen (wlen), .din (hold_q), .dout (tx_trim)
   );

   uart_hr_rdmux #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_rdmux (
      .rd_en (rd && sel), .target (target), .rx_trim (rx_trim),
      .ien_q (ien_q), .div_q (div_q), .ident (int_ident_i),
      .line_q (line_q), .modem_q (modem_q), .lstat (line_status_i),
      .mstat (modem_status_i), .scratch_q (scratch_q), .rdata (rdata)
   );

   assign tx_data_o    = tx_trim;
   assign tx_load_o    = load_q;
   assign rx_take_o    = take_q;
   assign line_ctrl_o  = line_q;
   assign fifo_ctrl_o  = fifo_q;
   assign modem_ctrl_o = modem_q;
   assign int_enable_o = ien_q;
   assign divisor_o    = div_q;

   AST_LOAD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load_o |-> $past(wr && !(cs0_n && cs1_n) && addr == '0
                          && !line_ctrl_o[BANK_BIT])); // R3

   AST_DIV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr) |-> $stable(divisor_o)); // R4

   AST_TAKE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rx_take_o |-> $past(rd && !(cs0_n && cs1_n) && addr == '0
                          && !line_ctrl_o[BANK_BIT])); // R9

   AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |-> rdata == '0); // R10

   AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr && !(cs0_n && cs1_n) && (addr == 3'd5 || addr == 3'd6))
      |-> ($stable(line_ctrl_o) && $stable(modem_ctrl_o)
           && $stable(int_enable_o) && $stable(fifo_ctrl_o))); // R7

   AST_NO_SELECT_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs0_n && cs1_n) |-> ($stable(line_ctrl_o) && $stable(divisor_o)
                                  && !tx_load_o && !rx_take_o)); // R1

endmodule

// File: tb/uart_hostregs_tb.sv
module uart_hostregs_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs0_n = 1'b1, cs1_n = 1'b1;
   logic [2:0] addr = '0;
   logic       rd = 1'b0, wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [7:0] rx_data_i = '0, line_status_i = '0, modem_status_i = '0, int_ident_i = '0;
   logic [7:0] tx_data_o, line_ctrl_o, fifo_ctrl_o, modem_ctrl_o, int_enable_o;
   logic [15:0] divisor_o;
   logic       tx_load_o, rx_take_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   uart_hostregs u_dut (
      .clk (clk), .rst_n (rst_n), .cs0_n (cs0_n), .cs1_n (cs1_n), .addr (addr),
      .rd (rd), .wr (wr), .wdata (wdata), .rdata (rdata),
      .rx_data_i (rx_data_i), .line_status_i (line_status_i),
      .modem_status_i (modem_status_i), .int_ident_i (int_ident_i),
      .tx_data_o (tx_data_o), .tx_load_o (tx_load_o), .rx_take_o (rx_take_o),
      .line_ctrl_o (line_ctrl_o), .fifo_ctrl_o (fifo_ctrl_o),
      .modem_ctrl_o (modem_ctrl_o), .int_enable_o (int_enable_o),
      .divisor_o (divisor_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one write access; returns at the falling edge after the sampling edge
   task automatic bus_wr(input logic [2:0] a, input logic [7:0] d, input bit use_cs1 = 1'b0,
                         input bit no_cs = 1'b0);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      if (!no_cs) begin
         if (use_cs1) cs1_n = 1'b0; else cs0_n = 1'b0;
      end
      @(negedge clk);
      wr = 1'b0; cs0_n = 1'b1; cs1_n = 1'b1;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [7:0] d, input bit use_cs1 = 1'b0,
                         input bit no_cs = 1'b0);
      @(negedge clk);
      addr = a; rd = 1'b1;
      if (!no_cs) begin
         if (use_cs1) cs1_n = 1'b0; else cs0_n = 1'b0;
      end
      #3 d = rdata;
      @(negedge clk);
      rd = 1'b0; cs0_n = 1'b1; cs1_n = 1'b1;
   endtask

   task automatic t_reset();
      check("R2 line", line_ctrl_o, 0);
      check("R2 fifo", fifo_ctrl_o, 0);
      check("R2 modem", modem_ctrl_o, 0);
      check("R2 ien", int_enable_o, 0);
      check("R2 divisor", divisor_o, 0);
      check("R2 txdata", tx_data_o, 0);
      check("R2 strobes", {tx_load_o, rx_take_o}, 0);
      check("R10 idle rdata", rdata, 0);
   endtask

   task automatic t_bank_clear();
      logic [7:0] d;
      bus_wr(3'd3, 8'h03);
      bus_wr(3'd0, 8'hA5);
      check("R3 tx_load pulse", tx_load_o, 1);
      check("R3 tx data", tx_data_o, 8'hA5);
      @(negedge clk);
      check("R3 tx_load one cycle", tx_load_o, 0);
      bus_wr(3'd1, 8'h0F);
      check("R3 ien", int_enable_o, 8'h0F);
      bus_rd(3'd1, d);
      check("R3 ien read", d, 8'h0F);
   endtask

   task automatic t_bank_set();
      logic [7:0] d;
      bus_wr(3'd3, 8'h83);
      bus_wr(3'd0, 8'h34);
      check("R4 no tx_load", tx_load_o, 0);
      bus_wr(3'd1, 8'h12);
      check("R4 divisor", divisor_o, 16'h1234);
      check("R4 ien untouched", int_enable_o, 8'h0F);
      check("R4 txdata untouched", tx_data_o, 8'hA5);
      bus_rd(3'd0, d);
      check("R4 div lo read", d, 8'h34);
      check("R9 no take when banked", rx_take_o, 0);
      bus_rd(3'd1, d);
      check("R4 div hi read", d, 8'h12);
   endtask

   task automatic t_addr2();
      logic [7:0] d;
      int_ident_i = 8'hC1;
      bus_rd(3'd2, d);
      check("R5 ident read bank set", d, 8'hC1);
      bus_wr(3'd2, 8'h47);
      check("R5 fifo write bank set", fifo_ctrl_o, 8'h47);
      bus_wr(3'd3, 8'h03);
      bus_rd(3'd2, d);
      check("R5 ident read bank clear", d, 8'hC1);
      bus_wr(3'd2, 8'h81);
      check("R5 fifo write bank clear", fifo_ctrl_o, 8'h81);
      check("R5 divisor kept", divisor_o, 16'h1234);
   endtask

   task automatic t_upper();
      logic [7:0] d;
      bus_wr(3'd3, 8'h1B);
      bus_rd(3'd3, d);
      check("R6 line rw", d, 8'h1B);
      bus_wr(3'd4, 8'h13);
      bus_rd(3'd4, d);
      check("R6 modem rw", d, 8'h13);
      check("R6 modem out", modem_ctrl_o, 8'h13);
      line_status_i = 8'h60;
      modem_status_i = 8'hB0;
      bus_rd(3'd5, d);
      check("R6 lstat read", d, 8'h60);
      bus_rd(3'd6, d);
      check("R6 mstat read", d, 8'hB0);
      bus_wr(3'd7, 8'h5A);
      bus_rd(3'd7, d);
      check("R6 scratch rw", d, 8'h5A);
   endtask

   task automatic t_ignored();
      logic [7:0] d;
      bus_wr(3'd5, 8'hFF);
      bus_wr(3'd6, 8'hFF);
      check("R7 line kept", line_ctrl_o, 8'h1B);
      check("R7 modem kept", modem_ctrl_o, 8'h13);
      check("R7 ien kept", int_enable_o, 8'h0F);
      check("R7 fifo kept", fifo_ctrl_o, 8'h81);
      check("R7 divisor kept", divisor_o, 16'h1234);
      check("R7 txdata kept", tx_data_o, 8'hA5);
      bus_rd(3'd7, d);
      check("R7 scratch kept", d, 8'h5A);
      bus_rd(3'd5, d);
      check("R7 lstat still input", d, 8'h60);
   endtask

   task automatic t_wordlen();
      logic [7:0] d;
      rx_data_i = 8'hFF;
      bus_wr(3'd3, 8'h00);
      bus_wr(3'd0, 8'hFF);
      check("R8 tx 5 bits", tx_data_o, 8'h1F);
      bus_rd(3'd0, d);
      check("R8 rx 5 bits", d, 8'h1F);
      check("R9 take pulse", rx_take_o, 1);
      @(negedge clk);
      check("R9 take one cycle", rx_take_o, 0);
      bus_wr(3'd3, 8'h01);
      check("R8 tx 6 bits", tx_data_o, 8'h3F);
      bus_rd(3'd0, d);
      check("R8 rx 6 bits", d, 8'h3F);
      bus_wr(3'd3, 8'h02);
      check("R8 tx 7 bits", tx_data_o, 8'h7F);
      bus_wr(3'd3, 8'h03);
      check("R8 tx 8 bits", tx_data_o, 8'hFF);
   endtask

   task automatic t_select();
      logic [7:0] d;
      bus_wr(3'd7, 8'h99, 1'b0, 1'b1);
      bus_rd(3'd7, d, 1'b1);
      check("R1 unselected write ignored", d, 8'h5A);
      bus_rd(3'd7, d, 1'b0, 1'b1);
      check("R1 unselected read zero", d, 0);
      bus_wr(3'd0, 8'h11, 1'b0, 1'b1);
      check("R1 no tx_load unselected", tx_load_o, 0);
      bus_wr(3'd7, 8'h3C, 1'b1);
      bus_rd(3'd7, d);
      check("R1 cs1 write", d, 8'h3C);
      @(negedge clk);
      cs0_n = 1'b0; addr = 3'd5;
      #3 check("R10 rdata zero without rd", rdata, 0);
      rd = 1'b1;
      #3 check("R10 rdata combinational", rdata, 8'h60);
      addr = 3'd4;
      #3 check("R10 follows address", rdata, 8'h13);
      @(negedge clk);
      rd = 1'b0; cs0_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bank_clear();
      t_bank_set();
      t_addr2();
      t_upper();
      t_ignored();
      t_wordlen();
      t_select();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule